// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Writes

A clocked single-port memory that registers its address, write data and every control on the rising clock edge. The read path is flow-through: no register sits between the array and the output. After the edge that starts or steps a read, the output shows the word at the new address within the same cycle. An external start address is loaded by one of two start strobes. A 2-bit counter then walks through the 4-word block around that address, one step for each cycle in which the advance input is low. A per-cycle order select chooses linear or interleaved order.

The chip is selected by three enables of mixed polarity. The processor-style strobe begins a read only, and it is ignored while the main enable is inactive. The cache-style strobe begins either a read or a write, depending on the write controls. A global-write input overrides the two byte-lane enables. The bidirectional data bus is split into an input port, an output port and a drive-enable output. The drive enable is asserted only on selected read cycles with the output enable low.

Top module: `burst_sram`

## Requirements
- R1: Each input is sampled on the rising clock edge. Right after the edge of a selected read cycle, `rdData` shows the stored word at that cycle's burst address (flow-through), with no extra cycle of latency.
- R2: The chip is selected only when `chipEnN`=0, `chipEnHi`=1 and `chipEnLoN`=0. A start strobe taken while any of these is inactive deselects the chip, and `rdDrive` stays 0 until a later selected start.
- R3: While `chipEnN`=1, a low `procStrobeN` is ignored. With `cacheStrobeN` high, the cycle is treated as a burst continue or suspend. A low `cacheStrobeN` with `chipEnN`=1 deselects the chip.
- R4: A low `procStrobeN` on a selected chip always starts a read burst at `addrIn`. The write controls are ignored in that cycle, and no word is changed.
- R5: A low `cacheStrobeN` with `procStrobeN` high on a selected chip starts a burst at `addrIn`. It is a write when the decode of R7 enables at least one lane, and a read otherwise.
- R6: With both strobes high on an active burst, `advN`=0 steps the counter to the next address and `advN`=1 keeps the current address. This holds for reads and for writes.
- R7: `globalWrN`=0 writes both lanes. Otherwise, with `laneWrEnN`=0, a lane is written where its `laneWrN` bit is 0: bit 0 is lane 0, which covers `wrData[WORD_W/2-1:0]`, and bit 1 is lane 1, the upper half. With 18-bit words each lane is 9 bits wide. When no lane is enabled, the cycle is a read.
- R8: `rdDrive` is 1 only on a selected read cycle with `outEnN`=0. It is always 0 on write cycles, whatever the state of `outEnN`.
- R9: The low two address bits are the loaded start bits plus the count, modulo 4, when `burstInterleave`=0, and the start bits XOR the count when it is 1. Both orders wrap inside the 4-word block. The upper address bits stay as loaded.
- R10: After reset every word reads as zero and the chip is deselected (`rdDrive`=0).
- R11: A continue or suspend cycle on a deselected chip leaves it deselected and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W | External start address |
| wrData | input | WORD_W | Write data (input half of the bus) |
| rdData | output | WORD_W | Flow-through read data (output half of the bus) |
| rdDrive | output | 1 | High when the memory drives the bus |
| chipEnN | input | 1 | Main enable, active low; gates the processor strobe |
| chipEnHi | input | 1 | Enable, active high |
| chipEnLoN | input | 1 | Enable, active low |
| procStrobeN | input | 1 | Processor-style start strobe, read only, active low |
| cacheStrobeN | input | 1 | Cache-style start strobe, read or write, active low |
| advN | input | 1 | Burst advance, active low |
| burstInterleave | input | 1 | 1 = interleaved order, 0 = linear order |
| globalWrN | input | 1 | Write all lanes, active low |
| laneWrEnN | input | 1 | Enables the per-lane writes, active low |
| laneWrN | input | 2 | Per-lane write selects, active low |
| outEnN | input | 1 | Output enable, active low |

## Verification
A wrong count or base register appears as a wrong word on `rdData` in the very cycle after the faulty edge, provided that the read addresses a block that holds distinct data. For that reason the bench fills a block with unique words before it walks both orders from each start offset. A wrong select or strobe decode appears at once as `rdDrive` being set or missing. A lost or misplaced write stays hidden until that word is read back, so the random phase keeps addresses in a small window to force early re-reads.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic             rd;
    logic             wr;
    logic [LANES-1:0] laneWr;
  } cmdStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              chipEnN,
  input  logic              chipEnHi,
  input  logic              chipEnLoN,
  input  logic              procStrobeN,
  input  logic              cacheStrobeN,
  input  logic              advN,
  input  logic              burstInterleave,
  input  logic              globalWrN,
  input  logic              laneWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  output cmdStrobes_t       cmd,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdActive,
  output logic              burstActive
);
  logic [ADDR_W-1:0] baseAddr, nextBase;
  logic [1:0]        cnt, nextCnt, lowBits;
  logic              nextActive, isWrite;
  logic              procStart, cacheStart, startReq, chipSel;
  logic [LANES-1:0]  laneMask;

  assign procStart  = !procStrobeN && !chipEnN;
  assign cacheStart = !cacheStrobeN;
  assign startReq   = procStart || cacheStart;
  assign chipSel    = !chipEnN && chipEnHi && !chipEnLoN;
  assign laneMask   = !globalWrN ? {LANES{1'b1}}
                    : (!laneWrEnN ? ~laneWrN : {LANES{1'b0}});

  always_comb begin
    nextActive = burstActive;
    nextBase   = baseAddr;
    nextCnt    = cnt;
    isWrite    = 1'b0;
    if (startReq) begin
      if (chipSel) begin
        nextActive = 1'b1;
        nextBase   = addrIn;
        nextCnt    = 2'd0;
        isWrite    = !procStart && (|laneMask);
      end else begin
        nextActive = 1'b0;
      end
    end else if (burstActive) begin
      nextCnt = cnt + {1'b0, !advN};
      isWrite = |laneMask;
    end
  end

  assign lowBits = burstInterleave ? (nextBase[1:0] ^ nextCnt)
                                   : (nextBase[1:0] + nextCnt);
  assign effAddr = {nextBase[ADDR_W-1:2], lowBits};

  assign cmd.wr     = nextActive && isWrite;
  assign cmd.rd     = nextActive && !isWrite;
  assign cmd.laneWr = cmd.wr ? laneMask : {LANES{1'b0}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      baseAddr    <= '0;
      cnt         <= 2'd0;
      rdAddr      <= '0;
      rdActive    <= 1'b0;
    end else begin
      burstActive <= nextActive;
      baseAddr    <= nextBase;
      cnt         <= nextCnt;
      rdAddr      <= effAddr;
      rdActive    <= cmd.rd;
    end
  end
endmodule

// File: rtl/burst_array.sv
module burst_array
  import burst_sram_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANE_W = WORD_W / LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobes_t       cmd,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      end else if (cmd.laneWr[g]) begin
        store[wrAddr] <= wrData[g*LANE_W +: LANE_W];
      end
    end

    assign rdData[g*LANE_W +: LANE_W] = store[rdAddr];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              rdDrive,
  input  logic              chipEnN,
  input  logic              chipEnHi,
  input  logic              chipEnLoN,
  input  logic              procStrobeN,
  input  logic              cacheStrobeN,
  input  logic              advN,
  input  logic              burstInterleave,
  input  logic              globalWrN,
  input  logic              laneWrEnN,
  input  logic [1:0]        laneWrN,
  input  logic              outEnN
);
  cmdStrobes_t       cmd;
  logic [ADDR_W-1:0] effAddr, rdAddr;
  logic              rdActive, burstActive;

  burst_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .chipEnN(chipEnN), .chipEnHi(chipEnHi), .chipEnLoN(chipEnLoN),
    .procStrobeN(procStrobeN), .cacheStrobeN(cacheStrobeN), .advN(advN),
    .burstInterleave(burstInterleave), .globalWrN(globalWrN),
    .laneWrEnN(laneWrEnN), .laneWrN(laneWrN),
    .cmd(cmd), .effAddr(effAddr), .rdAddr(rdAddr),
    .rdActive(rdActive), .burstActive(burstActive)
  );

  burst_array #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_array (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrAddr(effAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  assign rdDrive = rdActive && !outEnN;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEnN,
  input logic              chipEnHi,
  input logic              chipEnLoN,
  input logic              procStrobeN,
  input logic              cacheStrobeN,
  input logic              advN,
  input logic              globalWrN,
  input logic              outEnN,
  input logic              rdDrive,
  input logic              rdActive,
  input logic              burstActive,
  input logic [ADDR_W-1:0] rdAddr
);
  logic selOk;
  assign selOk = !chipEnN && chipEnHi && !chipEnLoN;

  AST_CACHE_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    (!cacheStrobeN && chipEnN) |=> !rdDrive); // R3

  AST_START_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (!cacheStrobeN && !chipEnHi) |=> !burstActive); // R2

  AST_PROC_ALWAYS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && selOk) |=> rdActive); // R4

  AST_GLOBAL_WRITE_START: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && !cacheStrobeN && selOk && !globalWrN) |=> !rdActive); // R7

  AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !rdDrive); // R8

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && procStrobeN && cacheStrobeN && advN) |=> $stable(rdAddr)); // R6

  AST_UPPER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && procStrobeN && cacheStrobeN)
    |=> rdAddr[ADDR_W-1:2] == $past(rdAddr[ADDR_W-1:2])); // R9

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!burstActive && procStrobeN && cacheStrobeN) |=> !burstActive); // R11
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .chipEnHi(chipEnHi),
  .chipEnLoN(chipEnLoN), .procStrobeN(procStrobeN), .cacheStrobeN(cacheStrobeN),
  .advN(advN), .globalWrN(globalWrN), .outEnN(outEnN), .rdDrive(rdDrive),
  .rdActive(rdActive), .burstActive(burstActive), .rdAddr(rdAddr)
);

// File: tb/test_burst_sram.sv
`timescale 1ns/1ps
module test_burst_sram;
  localparam int WORD_W = 18;
  localparam int DEPTH  = 256;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LANE_W = WORD_W / 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [WORD_W-1:0] wrData = '0;
  logic [WORD_W-1:0] rdData;
  logic              rdDrive;
  logic chipEnN = 1'b1, chipEnHi = 1'b0, chipEnLoN = 1'b1;
  logic procStrobeN = 1'b1, cacheStrobeN = 1'b1, advN = 1'b1;
  logic burstInterleave = 1'b0, globalWrN = 1'b1, laneWrEnN = 1'b1;
  logic [1:0] laneWrN = 2'b11;
  logic outEnN = 1'b1;

  always #2.5 clk = ~clk;

  burst_sram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_burst_sram (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .wrData(wrData), .rdData(rdData),
    .rdDrive(rdDrive), .chipEnN(chipEnN), .chipEnHi(chipEnHi),
    .chipEnLoN(chipEnLoN), .procStrobeN(procStrobeN),
    .cacheStrobeN(cacheStrobeN), .advN(advN),
    .burstInterleave(burstInterleave), .globalWrN(globalWrN),
    .laneWrEnN(laneWrEnN), .laneWrN(laneWrN), .outEnN(outEnN)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  string dataTag = "R1";

  logic [WORD_W-1:0] refMem [DEPTH];
  logic              refActive = 0, refRead = 0;
  logic [ADDR_W-1:0] refBase = '0, refAddr = '0;
  logic [1:0]        refCnt = '0;

  function automatic logic [ADDR_W-1:0] burstAddr(logic [ADDR_W-1:0] base,
                                                  logic [1:0] c, logic il);
    logic [1:0] off;
    off = il ? (base[1:0] ^ c) : 2'((base[1:0] + c) % 4);
    return {base[ADDR_W-1:2], off};
  endfunction

  task automatic chk(string tag, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // reference update for the edge just taken, then output check
  task automatic modelAndCheck();
    logic pStart, cStart, sel, wr;
    logic [1:0] mask;
    string tag;
    pStart = !procStrobeN && !chipEnN;
    cStart = !cacheStrobeN;
    sel    = !chipEnN && chipEnHi && !chipEnLoN;
    mask   = !globalWrN ? 2'b11 : (!laneWrEnN ? ~laneWrN : 2'b00);
    wr = 0;
    if (pStart || cStart) begin
      if (sel) begin
        refActive = 1; refBase = addrIn; refCnt = 0;
        wr  = !pStart && (mask != 0);
        tag = pStart ? "R4" : "R5";
      end else begin
        refActive = 0;
        tag = chipEnN ? "R3" : "R2";
      end
    end else if (refActive) begin
      refCnt = refCnt + {1'b0, !advN};
      wr  = (mask != 0);
      tag = (!procStrobeN) ? "R3" : "R6";
    end else tag = "R11";
    refRead = refActive && !wr;
    if (refActive) begin
      refAddr = burstAddr(refBase, refCnt, burstInterleave);
      if (wr) begin
        tag = (outEnN == 0) ? "R8" : "R7";
        if (mask[0]) refMem[refAddr][LANE_W-1:0] = wrData[LANE_W-1:0];
        if (mask[1]) refMem[refAddr][WORD_W-1:LANE_W] = wrData[WORD_W-1:LANE_W];
      end
    end
    #0.5;
    chk(tag, WORD_W'(rdDrive), WORD_W'(refRead && !outEnN));
    if (refRead && !outEnN) chk(dataTag, rdData, refMem[refAddr]);
  endtask

  task automatic cycle();
    @(posedge clk); #0.5;
    modelAndCheck();
    @(negedge clk);
  endtask

  task automatic idleCtl();
    chipEnN = 0; chipEnHi = 1; chipEnLoN = 0;
    procStrobeN = 1; cacheStrobeN = 1; advN = 1;
    globalWrN = 1; laneWrEnN = 1; laneWrN = 2'b11; outEnN = 0;
  endtask

  task automatic procRead(logic [ADDR_W-1:0] a);
    idleCtl(); addrIn = a; procStrobeN = 0; cycle();
  endtask

  task automatic cacheWrite(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
    idleCtl(); addrIn = a; cacheStrobeN = 0; globalWrN = 0; wrData = d; cycle();
  endtask

  task automatic contWrite(logic [WORD_W-1:0] d);
    idleCtl(); advN = 0; globalWrN = 0; wrData = d; cycle();
  endtask

  task automatic contRead(logic adv);
    idleCtl(); advN = !adv; cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R10", WORD_W'(rdDrive), '0);
    rstN = 1;
    @(negedge clk);
    // R10: fresh array reads zero, bus floats after reset with OE low
    idleCtl(); procStrobeN = 1; cycle();
    chk("R10", WORD_W'(rdDrive), '0);
    procRead(8'd37);
    chk("R10", rdData, '0);

    // fill block 0x40..0x43 with distinct words (linear writes)
    burstInterleave = 0;
    cacheWrite(8'h40, 18'h10A01);
    contWrite(18'h20B02);
    contWrite(18'h30C03);
    contWrite(18'h01D04);

    // R9: every start offset, both orders, including a suspend (R6)
    dataTag = "R9";
    for (int m = 0; m < 2; m++) begin
      for (int off = 0; off < 4; off++) begin
        procRead(8'h40 + 8'(off));
        burstInterleave = m[0];
        for (int b = 0; b < 3; b++) begin
          idleCtl(); burstInterleave = m[0]; advN = 0; cycle();
        end
        idleCtl(); burstInterleave = m[0]; advN = 1; cycle();
      end
    end
    burstInterleave = 0;
    dataTag = "R1";

    // R4: processor start ignores global write
    idleCtl(); addrIn = 8'h41; procStrobeN = 0; globalWrN = 0; wrData = '1; cycle();
    chk("R4", rdData, 18'h20B02);
    // R3: processor strobe with chipEnN high behaves as a continue
    idleCtl(); chipEnN = 1; procStrobeN = 0; advN = 0; cycle();
    chk("R3", rdData, 18'h30C03);
    // R7: lane 0 only write, then read back
    idleCtl(); addrIn = 8'h50; cacheStrobeN = 0; globalWrN = 0; wrData = 18'h3FFFF; cycle();
    idleCtl(); addrIn = 8'h50; cacheStrobeN = 0; laneWrEnN = 0; laneWrN = 2'b10;
    wrData = 18'h00055; cycle();
    procRead(8'h50);
    chk("R7", rdData, 18'h3FE55);
    // R8: write cycle with OE low does not drive
    cacheWrite(8'h51, 18'h12345);
    chk("R8", WORD_W'(rdDrive), '0);
    // R2: start with chipEnHi low deselects; R11: continue stays idle
    idleCtl(); chipEnHi = 0; cacheStrobeN = 0; cycle();
    contRead(1'b1);
    chk("R11", WORD_W'(rdDrive), '0);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      if (n % 500 == 0) burstInterleave = $urandom % 2;
      chipEnN      = ($urandom % 8 == 0);
      chipEnHi     = ($urandom % 8 != 0);
      chipEnLoN    = ($urandom % 8 == 0);
      procStrobeN  = ($urandom % 4 != 0);
      cacheStrobeN = ($urandom % 4 != 0);
      advN         = $urandom % 2;
      globalWrN    = ($urandom % 4 != 0);
      laneWrEnN    = $urandom % 2;
      laneWrN      = 2'($urandom);
      outEnN       = ($urandom % 5 == 0);
      addrIn       = ADDR_W'($urandom % 32);
      wrData       = WORD_W'($urandom);
      cycle();
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule